// File: doc/BRIEF.md
# Fall-Through Word-Chain FIFO

This block is a first-in first-out buffer of DEPTH words, WIDTH bits each (16 by 5 by default). It is built as a chain of word registers, each with its own valid bit, rather than as a RAM with pointers. A word enters at the input end of the chain. On every system clock, each occupied stage whose downstream neighbour is empty passes its word one step toward the output end. The word at the output end is presented on the read port until it is unloaded.

The write side has two load-strobe lines, and a word is captured on the rising edge of either one. The line that is not strobing acts as a gate: while it is held low, edges on the other line are ignored. The read side has an unload-strobe line, a ready flag and an active-low output enable. The data path has no pads. Instead, a drive-enable output and a zeroed data bus stand in for tri-state outputs.

A one-cycle low pulse marks each time the input-end stage is vacated by a forward move. An upstream unit can use this pulse as its unload strobe, which allows several units to be chained in depth. All strobe lines are asynchronous to the block. Each passes through a synchronizer of SYNC_STAGES flops clocked by the system clock, and its rising edges are detected after that. An active-low master reset clears every valid bit but leaves the stored data in place.

Top module: `ripple_fifo`

## Requirements
- R1: Words leave the read port in the order they were accepted, with each data bit equal to the written bit. Up to DEPTH words are held at once.
- R2: A word is captured from wr_data when one load line rises while the other load line is high. If both lines rise in the same cycle, exactly one word is captured.
- R3: While one load line is held low, rising edges on the other load line capture nothing.
- R4: in_rdy is high exactly when the input-end stage is empty. Once the chain has settled, it is low only when DEPTH words are held. A load edge while in_rdy is low is ignored.
- R5: out_rdy is high only when the output-end stage holds a word and the synchronized unload line is high.
- R6: A rising edge on unld_in while the output-end stage holds a word discards that word, and the next word then moves forward. A rising edge with no word held changes nothing.
- R7: While mrst_n is low, all valid bits are cleared, so in_rdy is 1 and out_rdy is 0 from the next cycle on. The stored output word and rd_data keep their values, and vac_n stays high.
- R8: vac_n goes low for exactly one cycle each time a word moves out of the input-end stage, in the cycle in which in_rdy returns high. Filling the last free location gives no pulse.
- R9: With out_en_n high, rd_drive is 0 and rd_data is all zeros. With out_en_n low, rd_drive is 1 and rd_data shows the output-end word.
- R10: A word written into an empty chain moves one stage per clock. With the unload line held high, out_rdy rises SYNC_STAGES+DEPTH clock edges after the load line rises (18 with the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mrst_n | input | 1 | Master reset, active low, sampled on clk |
| ld_a | input | 1 | Load strobe A, asynchronous |
| ld_b | input | 1 | Load strobe B, asynchronous |
| wr_data | input | WIDTH | Write data |
| unld_in | input | 1 | Unload strobe, asynchronous |
| out_en_n | input | 1 | Output enable, active low |
| rd_data | output | WIDTH | Output-end word (zero when disabled) |
| rd_drive | output | 1 | High when the read bus should be driven |
| in_rdy | output | 1 | Input-end stage empty |
| out_rdy | output | 1 | Valid word at the read port and unload line high |
| vac_n | output | 1 | One-cycle low pulse when the input-end stage vacates |

## Verification
The assertions assume that every strobe line holds each level for at least SYNC_STAGES clock cycles, so that the synchronizers see every edge, and that wr_data is steady around each load edge. The stimulus holds every strobe level for three cycles and keeps wr_data constant until the chain has settled. After each operation it waits long enough for any ripple to finish, so that the settled flag values can be compared with a queue model. The random phase mixes writes on either line, writes into a full chain, and unloads on full and empty chains.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;
   // synchronized strobe: level after the synchronizer and a one-cycle rise mark
   typedef struct packed {
      logic lvl;
      logic rise;
   } strobe_t;

   function automatic bit depth_ok(input int d);
      return d >= 2;
   endfunction
endpackage

// File: rtl/ripple_fifo_sync.sv
module ripple_fifo_sync
   import ripple_fifo_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic    clk,
   input  logic    din,
   output strobe_t q
);
   localparam int LAST = STAGES - 1;

   // sh[LAST] is the synchronized level, sh[STAGES] the previous one
   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      sh <= {sh[STAGES-1:0], din};
   end

   always_comb begin
      q.lvl  = sh[LAST];
      q.rise = sh[LAST] & ~sh[STAGES];
   end
endmodule

// File: rtl/ripple_fifo_stage.sv
module ripple_fifo_stage #(
   parameter int WIDTH = 5
) (
   input  logic             clk,
   input  logic             mrst_n,
   input  logic             take,
   input  logic             give,
   input  logic [WIDTH-1:0] din,
   output logic             vld,
   output logic [WIDTH-1:0] dat
);
   always_ff @(posedge clk) begin
      if (!mrst_n) vld <= 1'b0;
      else         vld <= (vld & ~give) | take;
   end

   // data is never cleared; only the valid bit marks it stale
   always_ff @(posedge clk) begin
      if (mrst_n && take) dat <= din;
   end
endmodule

// File: rtl/ripple_fifo_drive.sv
module ripple_fifo_drive #(
   parameter int WIDTH        = 5,
   parameter bit ZERO_WHEN_OFF = 1'b1
) (
   input  logic [WIDTH-1:0] word,
   input  logic             out_en_n,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_drive
);
   assign rd_drive = ~out_en_n;

   generate
      if (ZERO_WHEN_OFF) begin : g_gate
         assign rd_data = out_en_n ? '0 : word;
      end else begin : g_pass
         assign rd_data = word;
      end
   endgenerate
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
   import ripple_fifo_pkg::*;
#(
   parameter int WIDTH         = 5,
   parameter int DEPTH         = 16,
   parameter int SYNC_STAGES   = 2,
   parameter bit ZERO_WHEN_OFF = 1'b1
) (
   input  logic             clk,
   input  logic             mrst_n,
   input  logic             ld_a,
   input  logic             ld_b,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             unld_in,
   input  logic             out_en_n,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_drive,
   output logic             in_rdy,
   output logic             out_rdy,
   output logic             vac_n
);
   localparam int HEAD = 0;
   localparam int TAIL = DEPTH - 1;

   generate
      if (!depth_ok(DEPTH)) begin : g_bad_depth
         $error("ripple_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ripple_fifo: WIDTH must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ripple_fifo: SYNC_STAGES must be at least 2");
      end
   endgenerate

   strobe_t sa, sb, su;

   ripple_fifo_sync #(.STAGES(SYNC_STAGES)) u_sync_a (.clk(clk), .din(ld_a),    .q(sa));
   ripple_fifo_sync #(.STAGES(SYNC_STAGES)) u_sync_b (.clk(clk), .din(ld_b),    .q(sb));
   ripple_fifo_sync #(.STAGES(SYNC_STAGES)) u_sync_u (.clk(clk), .din(unld_in), .q(su));

   logic [DEPTH-1:0]            vld;
   logic [DEPTH-1:0][WIDTH-1:0] dat;
   logic [DEPTH-1:0]            take;
   logic [DEPTH-1:0]            give;
   logic                        load_fire;
   logic                        pop;

   // each load line gates the other
   assign load_fire = ((sa.rise & sb.lvl) | (sb.rise & sa.lvl)) & ~vld[HEAD];
   assign pop       = su.rise & vld[TAIL];

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_chain
         logic [WIDTH-1:0] din_i;
         if (gi == HEAD) begin : g_head
            assign take[gi] = load_fire;
            assign din_i    = wr_data;
         end else begin : g_body
            assign take[gi] = vld[gi-1] & ~vld[gi];
            assign din_i    = dat[gi-1];
         end
         if (gi == TAIL) begin : g_tail
            assign give[gi] = pop;
         end else begin : g_fwd
            assign give[gi] = vld[gi] & ~vld[gi+1];
         end

         ripple_fifo_stage #(.WIDTH(WIDTH)) u_stage (
            .clk    (clk),
            .mrst_n (mrst_n),
            .take   (take[gi]),
            .give   (give[gi]),
            .din    (din_i),
            .vld    (vld[gi]),
            .dat    (dat[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!mrst_n) vac_n <= 1'b1;
      else         vac_n <= ~give[HEAD];
   end

   assign in_rdy  = ~vld[HEAD];
   assign out_rdy = vld[TAIL] & su.lvl;

   ripple_fifo_drive #(.WIDTH(WIDTH), .ZERO_WHEN_OFF(ZERO_WHEN_OFF)) u_drive (
      .word     (dat[TAIL]),
      .out_en_n (out_en_n),
      .rd_data  (rd_data),
      .rd_drive (rd_drive)
   );
endmodule

// File: rtl/ripple_fifo_chk.sv
module ripple_fifo_chk #(
   parameter int WIDTH         = 5,
   parameter int SYNC_STAGES   = 2,
   parameter bit ZERO_WHEN_OFF = 1'b1
) (
   input logic             clk,
   input logic             mrst_n,
   input logic             unld_in,
   input logic             out_en_n,
   input logic [WIDTH-1:0] rd_data,
   input logic             rd_drive,
   input logic             in_rdy,
   input logic             out_rdy,
   input logic             vac_n
);
   // own history of the unload line, as deep as the synchronizer
   logic [SYNC_STAGES-1:0] uhist;
   always_ff @(posedge clk) begin
      uhist <= {uhist[SYNC_STAGES-2:0], unld_in};
   end

   a_r5_ready_needs_unload: assert property (@(posedge clk) disable iff (!mrst_n)
      out_rdy |-> uhist[SYNC_STAGES-1]);

   a_r7_reset_clears: assert property (@(posedge clk)
      !mrst_n |=> (in_rdy && !out_rdy));

   a_r8_pulse_on_vacate: assert property (@(posedge clk) disable iff (!mrst_n)
      !vac_n |-> (in_rdy && $past(!in_rdy)));

   a_r8_pulse_single: assert property (@(posedge clk) disable iff (!mrst_n)
      !vac_n |=> vac_n);

   a_r9_drive_follows_enable: assert property (@(posedge clk)
      rd_drive == !out_en_n);

   generate
      if (ZERO_WHEN_OFF) begin : g_zero_chk
         a_r9_zero_when_off: assert property (@(posedge clk)
            out_en_n |-> (rd_data == '0));
      end
   endgenerate
endmodule

bind ripple_fifo ripple_fifo_chk #(
   .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .ZERO_WHEN_OFF(ZERO_WHEN_OFF)
) u_chk (
   .clk(clk), .mrst_n(mrst_n), .unld_in(unld_in), .out_en_n(out_en_n),
   .rd_data(rd_data), .rd_drive(rd_drive), .in_rdy(in_rdy),
   .out_rdy(out_rdy), .vac_n(vac_n)
);

// File: tb/sim_ripple_fifo.sv
`timescale 1ns/1ps
module sim_ripple_fifo;
   localparam int W = 5;
   localparam int D = 16;
   localparam int S = 2;
   localparam int SETTLE = 24;

   logic         clk = 1'b0;
   logic         mrst_n = 1'b0;
   logic         ld_a = 1'b1, ld_b = 1'b1, unld_in = 1'b1, out_en_n = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic         rd_drive, in_rdy, out_rdy, vac_n;

   int total = 0, bad = 0, vac_cnt = 0;
   logic [W-1:0] model [$];

   always #2.5 clk = ~clk;

   ripple_fifo #(.WIDTH(W), .DEPTH(D), .SYNC_STAGES(S)) u0 (
      .clk(clk), .mrst_n(mrst_n), .ld_a(ld_a), .ld_b(ld_b), .wr_data(wr_data),
      .unld_in(unld_in), .out_en_n(out_en_n), .rd_data(rd_data),
      .rd_drive(rd_drive), .in_rdy(in_rdy), .out_rdy(out_rdy), .vac_n(vac_n)
   );

   always @(negedge clk) if (mrst_n && vac_n === 1'b0) vac_cnt++;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic bit exp_in_rdy();
      return model.size() < D;
   endfunction

   task automatic flags_check(input string tag);
      check(in_rdy == exp_in_rdy(), {tag, " R4 in_rdy"}, in_rdy, exp_in_rdy());
      check(out_rdy == (model.size() > 0), {tag, " R5 out_rdy"}, out_rdy, model.size() > 0);
   endtask

   task automatic write_word(input bit use_b, input logic [W-1:0] v);
      bit acc;
      acc = exp_in_rdy();
      @(negedge clk);
      wr_data = v;
      if (use_b) ld_b = 1'b0; else ld_a = 1'b0;
      idle(3);
      if (use_b) ld_b = 1'b1; else ld_a = 1'b1;
      idle(SETTLE);
      if (acc) model.push_back(v);
   endtask

   task automatic unload_word(input string tag);
      if (model.size() > 0) begin
         check(out_rdy == 1'b1, {tag, " R5 ready before unload"}, out_rdy, 1);
         check(rd_data == model[0], {tag, " R1 data order"}, rd_data, model[0]);
      end else begin
         check(out_rdy == 1'b0, {tag, " R6 empty not ready"}, out_rdy, 0);
      end
      @(negedge clk);
      unld_in = 1'b0;
      idle(3);
      unld_in = 1'b1;
      idle(SETTLE);
      if (model.size() > 0) void'(model.pop_front());
   endtask

   task automatic do_reset();
      @(negedge clk);
      mrst_n = 1'b0;
      idle(3);
      mrst_n = 1'b1;
      model.delete();
      idle(2);
   endtask

   initial begin
      #(5ns * 190000);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      logic [W-1:0] keep;
      void'($urandom(32'h1c3a_5eed));
      idle(4);
      mrst_n = 1'b1;
      idle(4);

      // reset state
      check(in_rdy == 1'b1, "R7 reset in_rdy", in_rdy, 1);
      check(out_rdy == 1'b0, "R7 reset out_rdy", out_rdy, 0);
      check(vac_n == 1'b1, "R8 reset vac_n", vac_n, 1);

      // R10 latency through an empty chain, plus one vacancy pulse
      vac_cnt = 0;
      @(negedge clk);
      wr_data = 5'h15;
      ld_a = 1'b0;
      idle(3);
      ld_a = 1'b1;
      n = 0;
      while (!out_rdy && n < 60) begin
         @(negedge clk);
         n++;
      end
      check(n == S + D, "R10 fall-through cycles", n, S + D);
      model.push_back(5'h15);
      idle(SETTLE);
      check(vac_cnt == 1, "R8 one pulse per vacate", vac_cnt, 1);
      unload_word("R10 word");
      flags_check("R6 after unload");

      // R6 unload on empty has no effect
      unload_word("R6 empty unload");
      write_word(1'b1, 5'h0a);
      flags_check("R6 after empty unload");
      unload_word("R6 word after empty unload");

      // R3 inhibit: B held low, A strobes capture nothing
      @(negedge clk);
      ld_b = 1'b0;
      wr_data = 5'h07;
      idle(3);
      for (int k = 0; k < 3; k++) begin
         ld_a = 1'b0; idle(3); ld_a = 1'b1; idle(3);
      end
      idle(SETTLE);
      check(out_rdy == 1'b0, "R3 inhibited strobes", out_rdy, 0);
      // releasing B with A high is itself a B edge: one word (R2)
      ld_b = 1'b1;
      idle(SETTLE);
      model.push_back(5'h07);
      flags_check("R2 release edge");
      unload_word("R2 release word");
      check(out_rdy == 1'b0, "R2 only one word", out_rdy, 0);

      // R2 both lines rising together: one word
      @(negedge clk);
      wr_data = 5'h1e;
      ld_a = 1'b0; ld_b = 1'b0;
      idle(3);
      ld_a = 1'b1; ld_b = 1'b1;
      idle(SETTLE);
      model.push_back(5'h1e);
      unload_word("R2 joint edge");
      check(out_rdy == 1'b0, "R2 joint edge single", out_rdy, 0);

      // R4 fill, extra write ignored, R8 no pulse on last fill
      for (int k = 0; k < D - 1; k++) write_word(k[0], W'(k * 3 + 1));
      vac_cnt = 0;
      write_word(1'b0, 5'h1f);
      check(vac_cnt == 0, "R8 no pulse when filling last slot", vac_cnt, 0);
      check(in_rdy == 1'b0, "R4 full", in_rdy, 0);
      write_word(1'b1, 5'h11);
      check(model.size() == D, "R4 model full", model.size(), D);
      flags_check("R4 after ignored write");
      vac_cnt = 0;
      unload_word("R1 first of full");
      check(vac_cnt == 1, "R8 pulse after unload from full", vac_cnt, 1);
      flags_check("R4 one free");

      // R5 unload line low hides ready; its rise then unloads (R6)
      @(negedge clk);
      unld_in = 1'b0;
      idle(3);
      check(out_rdy == 1'b0, "R5 unload low", out_rdy, 0);
      check(rd_data == model[0], "R1 data held", rd_data, model[0]);
      unld_in = 1'b1;
      idle(SETTLE);
      void'(model.pop_front());
      flags_check("R6 after rise");

      // R9 output enable
      @(negedge clk);
      out_en_n = 1'b1;
      @(negedge clk);
      check(rd_drive == 1'b0, "R9 drive off", rd_drive, 0);
      check(rd_data == '0, "R9 data zero", rd_data, 0);
      out_en_n = 1'b0;
      @(negedge clk);
      check(rd_drive == 1'b1, "R9 drive on", rd_drive, 1);
      check(rd_data == model[0], "R9 data shown", rd_data, model[0]);

      // R7 reset keeps output word
      keep = rd_data;
      vac_cnt = 0;
      do_reset();
      check(in_rdy == 1'b1, "R7 in_rdy after reset", in_rdy, 1);
      check(out_rdy == 1'b0, "R7 out_rdy after reset", out_rdy, 0);
      check(rd_data == keep, "R7 data kept", rd_data, keep);
      check(vac_cnt == 0, "R7 no pulse on reset", vac_cnt, 0);
      write_word(1'b0, 5'h13);
      unload_word("R7 after reset");

      // random mix
      for (int k = 0; k < 300; k++) begin
         int op;
         op = $urandom_range(0, 9);
         if (op < 6) write_word(op[0], W'($urandom));
         else        unload_word("R1 random");
         flags_check("R4 random");
      end
      while (model.size() > 0) unload_word("R1 drain");
      flags_check("R6 drained");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule